// File: doc/BRIEF.md
# Interrupt Pending Priority Selector

This block decides, every clock, whether a hart should leave its current instruction stream to service an interrupt, and if so which one. It combines the raw pending lines, the per-line enable mask, the per-line delegation mask, the current privilege level and the two global enable bits. From these it works out the set of interrupts that are allowed to fire now, and it picks the lowest-numbered one.

Whether a line is allowed to fire depends on privilege. A line whose delegation bit is clear belongs to machine level. It fires whenever the hart runs below machine level, and in machine mode only while the machine global enable is set. A delegated line belongs to supervisor level. It fires whenever the hart runs in user mode, in supervisor mode only while the supervisor global enable is set, and never in machine mode.

The decision is registered. The trap logic sees a stable take flag and a cause word one clock after the inputs that produced them. The top bit of the cause word marks the event as an interrupt rather than a synchronous exception.

Top module: `irq_select_top`

## Requirements
- R1: A line is a candidate only when both its pending bit and its enable bit are 1; a pending line whose enable bit is 0 is never reported.
- R2: A line with delegation bit 0 qualifies when privilege is user (2'b00) or supervisor (2'b01), or when privilege is machine (2'b11) and the machine global enable is 1.
- R3: A line with delegation bit 1 qualifies when privilege is user, or when privilege is supervisor and the supervisor global enable is 1; it never qualifies in machine mode.
- R4: When several lines qualify, the code reported in cause_o[3:0] is the index of the lowest-numbered qualifying line, including index 0 and index 15.
- R5: When no line qualifies, take_o is 0 and cause_o is all zeros.
- R6: Whenever take_o is 1, cause_o[4] (the interrupt flag) is 1.
- R7: take_o and cause_o reflect the inputs present at the previous rising clock edge and do not change between edges.
- R8: While rst_n is low, take_o and cause_o are 0, regardless of the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| pend_i | input | 16 | Pending interrupt lines |
| enab_i | input | 16 | Per-line enable mask |
| deleg_i | input | 16 | Per-line delegation mask (1 = supervisor level) |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| m_gie_i | input | 1 | Machine global interrupt enable |
| s_gie_i | input | 1 | Supervisor global interrupt enable |
| take_o | output | 1 | Registered request to take an interrupt |
| cause_o | output | 5 | Registered cause: bit 4 interrupt flag, bits 3:0 line index |

## Verification
The assertions assume that the privilege input never carries the reserved value 2'b10, and one property states this explicitly. The bench drives only user, supervisor and machine codes. The assertions also assume that the inputs are stable at the rising edge. The bench therefore changes every input on the falling edge and samples the outputs a short time after the rising edge, so each check sees exactly one registered decision.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  parameter int unsigned LINES = 16;
  localparam int unsigned CODE_W = $clog2(LINES);

  typedef enum logic [1:0] {
    PRIV_USER  = 2'b00,
    PRIV_SUPER = 2'b01,
    PRIV_RSVD  = 2'b10,
    PRIV_MACH  = 2'b11
  } priv_e;
endpackage

// File: rtl/irq_gate.sv
module irq_gate
  import irq_sel_pkg::*;
#(
  parameter int unsigned N = LINES
) (
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] enab_i,
  input  logic [N-1:0] deleg_i,
  input  logic [1:0]   priv_i,
  input  logic         m_gie_i,
  input  logic         s_gie_i,
  output logic [N-1:0] qual_o
);
  logic [N-1:0] cand;
  logic         mach_ok;
  logic         super_ok;

  always_comb begin
    cand     = pend_i & enab_i;
    mach_ok  = (priv_i != PRIV_MACH) || m_gie_i;
    super_ok = (priv_i == PRIV_USER) || ((priv_i == PRIV_SUPER) && s_gie_i);
    qual_o   = (cand & ~deleg_i & {N{mach_ok}}) |
               (cand &  deleg_i & {N{super_ok}});
  end
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int unsigned N = 16,
  localparam int unsigned CW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [CW-1:0] idx_o
);
  logic [N:0]   clear_below;
  logic [N-1:0] grant;

  assign clear_below[0] = 1'b1;

  for (genvar g = 0; g < N; g++) begin : g_chain
    assign grant[g]         = req_i[g] & clear_below[g];
    assign clear_below[g+1] = clear_below[g] & ~req_i[g];
  end

  always_comb begin
    idx_o = '0;
    for (int unsigned k = 0; k < N; k++) begin
      if (grant[k]) idx_o = idx_o | CW'(k);
    end
    any_o = ~clear_below[N];
  end
endmodule

// File: rtl/irq_select_top.sv
module irq_select_top
  import irq_sel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  pend_i,
  input  logic [LINES-1:0]  enab_i,
  input  logic [LINES-1:0]  deleg_i,
  input  logic [1:0]        priv_i,
  input  logic              m_gie_i,
  input  logic              s_gie_i,
  output logic              take_o,
  output logic [CODE_W:0]   cause_o
);
  logic [LINES-1:0]  qual;
  logic              any_q;
  logic [CODE_W-1:0] idx;
  logic              take_d;
  logic [CODE_W:0]   cause_d;
  logic              upd_en;

  irq_gate #(.N(LINES)) u_gate (
    .pend_i  (pend_i),
    .enab_i  (enab_i),
    .deleg_i (deleg_i),
    .priv_i  (priv_i),
    .m_gie_i (m_gie_i),
    .s_gie_i (s_gie_i),
    .qual_o  (qual)
  );

  irq_lowest_pick #(.N(LINES)) u_pick (
    .req_i (qual),
    .any_o (any_q),
    .idx_o (idx)
  );

  always_comb begin
    upd_en  = 1'b1;
    take_d  = any_q;
    cause_d = any_q ? {1'b1, idx} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_o  <= 1'b0;
      cause_o <= '0;
    end else if (upd_en) begin
      take_o  <= take_d;
      cause_o <= cause_d;
    end
  end

  p_priv_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    priv_i != PRIV_RSVD);

  p_mach_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i == PRIV_MACH && !m_gie_i) |=> !take_o);

  p_cand_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ((($past(pend_i) & $past(enab_i)) >> cause_o[CODE_W-1:0]) & 1) != 0);

  p_lowest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (($past(qual) & ((LINES'(1) << cause_o[CODE_W-1:0]) - LINES'(1))) == '0));

  p_none_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> cause_o == '0);

  p_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> cause_o[CODE_W]);

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> take_o == $past(|qual));
endmodule

// File: tb/irq_select_top_tb.sv
module irq_select_top_tb;
  logic        clk;
  logic        rst_n;
  logic [15:0] pend_i, enab_i, deleg_i;
  logic [1:0]  priv_i;
  logic        m_gie_i, s_gie_i;
  logic        take_o;
  logic [4:0]  cause_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  irq_select_top u_dut (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .enab_i(enab_i),
    .deleg_i(deleg_i), .priv_i(priv_i), .m_gie_i(m_gie_i),
    .s_gie_i(s_gie_i), .take_o(take_o), .cause_o(cause_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Vector: pend, enab, deleg, priv, m_gie, s_gie, exp_take, exp_code
  localparam int NV = 13;
  localparam logic [57:0] VEC [NV] = '{
    {16'h0088, 16'hFFFF, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b1, 4'd3},  // R2 R4
    {16'h0088, 16'h0080, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b1, 4'd7},  // R1
    {16'h00A0, 16'hFFFF, 16'h0000, 2'd3, 1'b0, 1'b1, 1'b0, 4'd0},  // R2
    {16'h00A0, 16'hFFFF, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b1, 4'd5},  // R2
    {16'h0022, 16'hFFFF, 16'h0022, 2'd1, 1'b1, 1'b0, 1'b0, 4'd0},  // R3
    {16'h0022, 16'hFFFF, 16'h0022, 2'd1, 1'b0, 1'b1, 1'b1, 4'd1},  // R3
    {16'h0022, 16'hFFFF, 16'h0022, 2'd3, 1'b1, 1'b1, 1'b0, 4'd0},  // R3
    {16'h0022, 16'hFFFF, 16'h0002, 2'd1, 1'b0, 1'b0, 1'b1, 4'd5},  // R2 R3
    {16'h0022, 16'hFFFF, 16'h0002, 2'd0, 1'b0, 1'b0, 1'b1, 4'd1},  // R4
    {16'h8000, 16'h8000, 16'h0000, 2'd1, 1'b0, 1'b0, 1'b1, 4'd15}, // R4
    {16'h0000, 16'hFFFF, 16'h0000, 2'd0, 1'b1, 1'b1, 1'b0, 4'd0},  // R5
    {16'hFFFF, 16'h0000, 16'h0000, 2'd0, 1'b1, 1'b1, 1'b0, 4'd0},  // R1
    {16'hFFFF, 16'hFFFF, 16'hFFFF, 2'd0, 1'b0, 1'b0, 1'b1, 4'd0}   // R4
  };

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [57:0] v);
    {pend_i, enab_i, deleg_i, priv_i, m_gie_i, s_gie_i} = v[57:5];
  endtask

  initial begin
    rst_n = 1'b0;
    pend_i = '0; enab_i = '0; deleg_i = '0; priv_i = 2'd0;
    m_gie_i = 1'b0; s_gie_i = 1'b0;
    // R8: reset holds outputs at zero even with a qualifying line
    pend_i = 16'h0001; enab_i = 16'h0001;
    repeat (3) @(posedge clk);
    #1;
    check("R8 take in reset", {4'd0, take_o}, 5'd0);
    check("R8 cause in reset", cause_o, 5'd0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk) drive(VEC[i]);
      @(posedge clk); #1;
      check($sformatf("R2/R3/R4 vec%0d take", i), {4'd0, take_o}, {4'd0, VEC[i][4]});
      // R6: flag set with take; R5: zero cause when none
      check($sformatf("R5/R6 vec%0d cause", i), cause_o,
            VEC[i][4] ? {1'b1, VEC[i][3:0]} : 5'd0);
    end

    // R7: output holds the previous decision until the next edge
    @(negedge clk) drive(VEC[9]);
    @(posedge clk); #1;
    check("R7 settled", cause_o, 5'h1F);
    @(negedge clk) drive(VEC[0]);
    #1;
    check("R7 before edge", cause_o, 5'h1F);
    @(posedge clk); #1;
    check("R7 after edge", cause_o, 5'h13);

    // R8: asynchronous reset mid-run clears outputs
    @(negedge clk) rst_n = 1'b0;
    #1;
    check("R8 async clear", {take_o, cause_o[3:0]}, 5'd0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    check("R8 resume", cause_o, 5'h13);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: got=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule